// File: doc/BRIEF.md
# System Address Range Decoder

This block turns a physical address into a memory target: a socket id, a memory-controller index and a channel index. It holds up to four per-node register sets. Each set has a table of range rules, a matching table of interleave lists, a packed routing word and a source id. A single write port loads all of them, together with two global bounds that mark the memory hole below 4 GiB and the top of memory.

A request is accepted when `req_ready` is high. The block checks the global bounds first. It then walks the rule table of node 0, one entry per clock. The matching rule picks a 4-bit target from its interleave list, using three address bits. If that target belongs to another node, the walk starts again once on the node whose source id matches. For a local target, the block may apply a modulo-3 or modulo-2 channel selection before it reads the controller and channel fields from the routing word. The modulo-3 remainder comes from a bit-serial subtractor, so that path always costs a fixed number of extra cycles. The result is shown for one cycle on `rsp_valid`. `req_ready` stays low from acceptance until that cycle.

Top module: `sys_addr_decoder`

## Requirements
- R1: An accepted address that is at or above the top-of-memory bound, or at or above the low bound and below 0x1_0000_0000, gives `rsp_err`=1 with `rsp_valid` in the cycle right after acceptance.
- R2: Rules are examined in index order, starting at index 0, one per cycle. An entry matches when its bit 0 (enable) is set and the address lies between the running lower bound and the entry's limit, both inclusive. The lower bound starts at 0 and becomes limit+1 after every entry that does not match, enabled or not. The response comes one cycle after the matching entry is examined.
- R3: An entry's limit is rule bits 26:7 placed at address bits 45:26, with address bits 25:0 all ones.
- R4: Rule bits 2:1 choose where the 3-bit index i starts in the address: bit 6, 8, 12 or 30 for values 0 to 3. The target nibble is bits 4i+3:4i of the entry's interleave list. When nibble bit 3 is set, the target is local and its id is nibble bits 2:0. With rule bit 27 clear, that id is the logical channel.
- R5: A nibble with bit 3 clear names a remote node. The walk restarts from index 0 and lower bound 0 on the lowest-numbered node whose source-id word has bit 3 (present) set and bits 2:0 equal to the nibble's bits 2:0. `rsp_socket` reports the source id of the node that resolves the address.
- R6: If a second remote target is hit, or no present node has the requested id, the response has `rsp_err`=1.
- R7: With rule bit 27 set, the address is shifted right by 6, 8 or 12 for rule bits 31:30 equal to 0, 1 or 2. This path adds 46 cycles. Value 3 gives `rsp_err`=1 without the extra cycles.
- R8: With rule bit 27 set, rule bits 6:5 choose an intermediate value v from the shifted address s: 0 gives s mod 3, 1 gives s mod 2, 2 gives ((s mod 2)<<1)|(~(s mod 2)&1), 3 gives (s mod 2)<<1. The logical channel is (v<<1)|(target id bit 0).
- R9: For logical channel L, `rsp_mc` is bits 3L+2:3L of the node's routing word. `rsp_chan` is bits 18+2L+1:18+2L. Bits above 31 read as zero.
- R10: `req_ready` is high only while idle. `rsp_valid` is a single-cycle pulse. If no entry matches after all 24 entries, the response has `rsp_err`=1.
- R11: A write with `cfg_we` stores `cfg_wdata` according to `cfg_sel`. The codes are: 0 rule[`cfg_node`][`cfg_idx`], 1 interleave list, 2 routing word, 3 source id (bits 3:0), 4 low bound, 5 top bound bits 31:0, 6 top bound bits 45:32.
- R12: When `rsp_err` is 1, `rsp_socket`, `rsp_mc` and `rsp_chan` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register class select |
| cfg_node | input | 2 | Node set index |
| cfg_idx | input | 5 | Rule index |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | 46 | Physical address |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Decode failed |
| rsp_socket | output | 3 | Source id of resolving node |
| rsp_mc | output | 3 | Memory-controller index |
| rsp_chan | output | 2 | Channel index |

## Verification
The assertions assume that the register set is written only while the block is idle, so the bounds they read do not move under an active decode. They also assume that a request is presented only when `req_ready` is high. The bench follows both rules. It reprograms rules only between transactions, and it raises `req_valid` for a single cycle while the block is idle. It then waits for the response. Its reference model computes the result and the exact response cycle for each address, and it compares `rsp_valid` against that cycle on every clock.

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder #(
  parameter int N_NODES = 4,
  parameter int N_RULES = 24,
  parameter int MOD_STEPS = 46
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [1:0]  cfg_node,
  input  logic [4:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [45:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [2:0]  rsp_socket,
  output logic [2:0]  rsp_mc,
  output logic [1:0]  rsp_chan
);
  localparam int AW = 46;
  localparam int IW = $clog2(N_RULES);
  localparam int NW = $clog2(N_NODES);
  localparam int CW = $clog2(MOD_STEPS);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_MOD, S_FIN} st_t;

  logic [31:0] rule_r [N_NODES][N_RULES];
  logic [31:0] ilv_r  [N_NODES][N_RULES];
  logic [31:0] route_r[N_NODES];
  logic [3:0]  src_r  [N_NODES];
  logic [31:0] tolm_q;
  logic [AW-1:0] tohm_q;

  st_t st;
  logic [AW-1:0] addr_q, lower_q, shreg;
  logic [NW-1:0] node_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic remote_q, err_q, mod3_q, b0_q;
  logic [1:0] asm2_q, rem_q;
  logic [2:0] tid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < N_NODES; n++) begin
        for (int i = 0; i < N_RULES; i++) begin
          rule_r[n][i] <= '0;
          ilv_r[n][i]  <= '0;
        end
        route_r[n] <= '0;
        src_r[n]   <= '0;
      end
      tolm_q <= '0;
      tohm_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: rule_r[cfg_node][cfg_idx[IW-1:0]] <= cfg_wdata;
        3'd1: ilv_r[cfg_node][cfg_idx[IW-1:0]]  <= cfg_wdata;
        3'd2: route_r[cfg_node] <= cfg_wdata;
        3'd3: src_r[cfg_node]   <= cfg_wdata[3:0];
        3'd4: tolm_q <= cfg_wdata;
        3'd5: tohm_q[31:0] <= cfg_wdata;
        3'd6: tohm_q[AW-1:32] <= cfg_wdata[AW-33:0];
        default: ;
      endcase
    end
  end

  wire range_bad = (req_addr >= tohm_q) ||
                   (req_addr >= {14'd0, tolm_q} && req_addr < 46'h1_0000_0000);

  wire [31:0]   cur = rule_r[node_q][idx_q];
  wire [AW-1:0] lim = {cur[26:7], 26'h3FF_FFFF};
  wire          hit = cur[0] && addr_q >= lower_q && addr_q <= lim;

  logic [2:0] ii;
  always_comb
    case (cur[2:1])
      2'd0: ii = addr_q[8:6];
      2'd1: ii = addr_q[10:8];
      2'd2: ii = addr_q[14:12];
      default: ii = addr_q[32:30];
    endcase

  wire [3:0] nib = ilv_r[node_q][idx_q][{ii, 2'b00} +: 4];

  logic fnd;
  logic [NW-1:0] fnode;
  always_comb begin
    fnd = 1'b0;
    fnode = '0;
    for (int n = N_NODES - 1; n >= 0; n--)
      if (src_r[n][3] && src_r[n][2:0] == nib[2:0]) begin
        fnd = 1'b1;
        fnode = NW'(n);
      end
  end

  logic [3:0] sh;
  always_comb
    case (cur[31:30])
      2'd0: sh = 4'd6;
      2'd1: sh = 4'd8;
      default: sh = 4'd12;
    endcase
  wire [AW-1:0] shifted = addr_q >> sh;

  wire [2:0] rem_t  = {rem_q, shreg[AW-1]};
  wire [1:0] rem_nx = (rem_t >= 3'd3) ? 2'(rem_t - 3'd3) : rem_t[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0; lower_q <= '0; shreg <= '0;
      node_q <= '0; idx_q <= '0; cnt_q <= '0;
      remote_q <= 1'b0; err_q <= 1'b0; mod3_q <= 1'b0; b0_q <= 1'b0;
      asm2_q <= '0; rem_q <= '0; tid_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr; node_q <= '0; idx_q <= '0; lower_q <= '0;
          remote_q <= 1'b0; mod3_q <= 1'b0; err_q <= range_bad;
          st <= range_bad ? S_FIN : S_SCAN;
        end
        S_SCAN: if (hit) begin
          if (!nib[3]) begin
            if (remote_q || !fnd) begin
              err_q <= 1'b1; st <= S_FIN;
            end else begin
              node_q <= fnode; remote_q <= 1'b1; idx_q <= '0; lower_q <= '0;
            end
          end else begin
            tid_q <= nib[2:0];
            asm2_q <= cur[6:5];
            if (!cur[27]) st <= S_FIN;
            else if (cur[31:30] == 2'd3) begin
              err_q <= 1'b1; st <= S_FIN;
            end else begin
              mod3_q <= 1'b1; shreg <= shifted; b0_q <= shifted[0];
              rem_q <= '0; cnt_q <= CW'(MOD_STEPS - 1); st <= S_MOD;
            end
          end
        end else if (idx_q == IW'(N_RULES - 1)) begin
          err_q <= 1'b1; st <= S_FIN;
        end else begin
          idx_q <= idx_q + 1'b1;
          lower_q <= lim + 1'b1;
        end
        S_MOD: begin
          rem_q <= rem_nx;
          shreg <= shreg << 1;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == '0) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [1:0] inter;
  always_comb
    case (asm2_q)
      2'd0: inter = rem_q;
      2'd1: inter = {1'b0, b0_q};
      2'd2: inter = {b0_q, ~b0_q};
      default: inter = {b0_q, 1'b0};
    endcase

  wire [2:0]  lchan = mod3_q ? {inter, tid_q[0]} : tid_q;
  wire [35:0] rw = {4'd0, route_r[node_q]};

  assign req_ready  = (st == S_IDLE);
  assign rsp_valid  = (st == S_FIN);
  assign rsp_err    = err_q;
  assign rsp_socket = err_q ? 3'd0 : src_r[node_q][2:0];
  assign rsp_mc     = err_q ? 3'd0 : rw[6'(lchan) * 6'd3 +: 3];
  assign rsp_chan   = err_q ? 2'd0 : rw[6'd18 + 6'(lchan) * 6'd2 +: 2];
endmodule

module sys_addr_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [45:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [2:0]  rsp_socket,
  input logic [2:0]  rsp_mc,
  input logic [1:0]  rsp_chan,
  input logic [31:0] tolm,
  input logic [45:0] tohm
);
  wire accept = req_valid && req_ready;

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_idle_after_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready && !rsp_valid);

  assert_top_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_addr >= tohm |=> rsp_valid && rsp_err);

  assert_scan_takes_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_addr < tohm && req_addr < {14'd0, tolm} |=> !rsp_valid);

  assert_err_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_socket == 3'd0 && rsp_mc == 3'd0 && rsp_chan == 2'd0);
endmodule

bind sys_addr_decoder sys_addr_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_socket(rsp_socket), .rsp_mc(rsp_mc), .rsp_chan(rsp_chan),
  .tolm(tolm_q), .tohm(tohm_q)
);

// File: tb/sys_addr_decoder_tb.sv
module sys_addr_decoder_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [1:0] cfg_node = 0;
  logic [4:0] cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic req_valid = 0;
  logic [45:0] req_addr = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [2:0] rsp_socket, rsp_mc;
  logic [1:0] rsp_chan;

  int errors = 0, checks = 0;

  logic [31:0] b_rule[4][24];
  logic [31:0] b_ilv[4][24];
  logic [31:0] b_route[4];
  logic [3:0]  b_src[4];
  longint b_tolm = 0, b_tohm = 0;

  always #5 clk = ~clk;

  sys_addr_decoder u_dut (.*);

  task automatic check(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int node, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_node = 2'(node); cfg_idx = 5'(idx); cfg_wdata = d;
    case (sel)
      0: b_rule[node][idx] = d;
      1: b_ilv[node][idx] = d;
      2: b_route[node] = d;
      3: b_src[node] = d[3:0];
      4: b_tolm = longint'(d);
      5: b_tohm = (b_tohm & 64'hFFFF_FFFF_0000_0000) | longint'(d);
      6: b_tohm = (b_tohm & 64'hFFFF_FFFF) | (longint'(d[13:0]) << 32);
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [31:0] mk(bit en, int il, int asm2, bit m3, int m3m, int lim);
    return {2'(m3m), 2'b00, m3, 20'(lim), 2'(asm2), 2'b00, 2'(il), en};
  endfunction

  function automatic void model(input longint a, output bit e, output int s,
                                output int m, output int c, output int lat);
    int node, hit, ii, tid, lchan, inter, sh;
    bit rmt, found;
    longint lo, lim, sa;
    logic [31:0] r;
    int nib;
    e = 0; s = 0; m = 0; c = 0; lat = 0;
    if (a >= b_tohm || (a >= b_tolm && a < 64'h1_0000_0000)) begin e = 1; return; end
    node = 0; rmt = 0; hit = 0; tid = 0; r = 0;
    while (1) begin
      lo = 0; found = 0;
      for (int i = 0; i < 24; i++) begin
        lat++;
        r = b_rule[node][i];
        lim = (longint'(r[26:7]) << 26) | 64'h3FF_FFFF;
        if (r[0] && a >= lo && a <= lim) begin found = 1; hit = i; break; end
        lo = lim + 1;
      end
      if (!found) begin e = 1; return; end
      case (r[2:1])
        0: ii = int'((a >> 6) & 7);
        1: ii = int'((a >> 8) & 7);
        2: ii = int'((a >> 12) & 7);
        default: ii = int'((a >> 30) & 7);
      endcase
      nib = int'((b_ilv[node][hit] >> (4 * ii)) & 15);
      tid = nib & 7;
      if (nib < 8) begin
        int nn;
        if (rmt) begin e = 1; return; end
        nn = -1;
        for (int n = 3; n >= 0; n--)
          if (b_src[n][3] && int'(b_src[n][2:0]) == tid) nn = n;
        if (nn < 0) begin e = 1; return; end
        node = nn; rmt = 1;
        continue;
      end
      break;
    end
    if (r[27]) begin
      if (r[31:30] == 3) begin e = 1; return; end
      sh = (r[31:30] == 0) ? 6 : (r[31:30] == 1) ? 8 : 12;
      sa = a >> sh;
      lat += 46;
      case (r[6:5])
        0: inter = int'(sa % 3);
        1: inter = int'(sa % 2);
        2: inter = (sa % 2 == 1) ? 2 : 1;
        default: inter = int'(sa % 2) * 2;
      endcase
      lchan = inter * 2 + (tid & 1);
    end else lchan = tid;
    m = int'(({4'd0, b_route[node]} >> (3 * lchan)) & 7);
    c = int'(({4'd0, b_route[node]} >> (18 + 2 * lchan)) & 3);
    s = int'(b_src[node][2:0]);
  endfunction

  task automatic run(input longint a, input string rq);
    bit e; int s, m, c, lat, cnt;
    model(a, e, s, m, c, lat);
    @(negedge clk);
    req_valid = 1; req_addr = 46'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    cnt = 0;
    while (1) begin
      if (cnt < lat) check({rq, " R10 ready low while busy"}, req_ready, 0);
      if (rsp_valid) begin
        check({rq, " timing"}, cnt, lat);
        check({rq, " R12 err"}, rsp_err, e);
        check({rq, " R5 socket"}, rsp_socket, s);
        check({rq, " R9 mc"}, rsp_mc, m);
        check({rq, " R9 chan"}, rsp_chan, c);
        @(negedge clk);
        check({rq, " R10 pulse"}, rsp_valid, 0);
        break;
      end
      if (cnt > lat + 2) begin check({rq, " R10 no response"}, 0, 1); break; end
      @(negedge clk);
      cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10: watchdog expired, actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 24; i++) begin b_rule[n][i] = 0; b_ilv[n][i] = 0; end
      b_route[n] = 0; b_src[n] = 0;
    end
    repeat (3) @(negedge clk);
    check("R10 reset ready", req_ready, 1);
    check("R10 reset valid", rsp_valid, 0);
    rst_n = 1;
    // R11 program bounds, ids, routes
    wr(4, 0, 0, 32'h8000_0000);
    wr(5, 0, 0, 32'h0);
    wr(6, 0, 0, 32'h10);
    wr(3, 0, 0, 32'h8);
    wr(3, 1, 0, 32'hD);
    wr(3, 2, 0, 32'hA);
    wr(2, 0, 0, 32'hB5A3_1C97);
    wr(2, 1, 0, 32'h7E1D_4A62);
    // node 0 rules
    wr(0, 0, 0, mk(1, 0, 0, 0, 0, 1));  wr(1, 0, 0, 32'hFEDC_BA98);
    wr(0, 0, 1, mk(0, 0, 0, 0, 0, 3));  wr(1, 0, 1, 32'hFEDC_BA98);
    wr(0, 0, 2, mk(1, 1, 0, 1, 0, 5));  wr(1, 0, 2, 32'h9999_9999);
    wr(0, 0, 3, mk(1, 2, 0, 0, 0, 7));  wr(1, 0, 3, 32'h5555_5555);
    wr(0, 0, 4, mk(1, 0, 0, 0, 0, 9));  wr(1, 0, 4, 32'h6666_6666);
    wr(0, 0, 5, mk(1, 0, 0, 1, 3, 32'h200)); wr(1, 0, 5, 32'h8888_8888);
    // node 1 rules
    wr(0, 1, 0, mk(1, 2, 0, 0, 0, 6));  wr(1, 1, 0, 32'hBADC_FE89);
    wr(0, 1, 1, mk(1, 0, 0, 0, 0, 7));  wr(1, 1, 1, 32'h0000_0000);

    // R1 bounds
    run(64'h9000_0000, "R1 hole");
    run(64'h10_0000_0000, "R1 top");
    run(64'h7FFF_FFFF, "R7 mode3 below hole");
    run(64'h1_0000_0000, "R7 mode3 above 4G");
    run(64'hF_FFFF_FFFF, "R10 no match");
    // R2/R3 disabled entry advances lower bound
    run(64'h0800_0040, "R2 disabled range");
    run(64'h07FF_FFFF, "R3 limit edge");
    // R4 local ids
    run(64'h0, "R4 idx0");
    run(64'h40, "R4 idx1");
    run(64'h1C0, "R9 lchan7");
    wr(0, 0, 0, mk(1, 1, 0, 0, 0, 1));
    run(64'h500, "R4 mode1");
    wr(0, 0, 0, mk(1, 2, 0, 0, 0, 1));
    run(64'h3000, "R4 mode2");
    // R7/R8 mod3 variants
    for (int mm = 0; mm < 3; mm++)
      for (int am = 0; am < 4; am++) begin
        wr(0, 0, 2, mk(1, 1, am, 1, mm, 5));
        run(64'h1000_0000 + 64'h1040, "R8 mod");
        run(64'h1000_0000 + 64'h2D7C0, "R8 mod");
        run(64'h17FF_FFFF, "R7 mod");
      end
    // R5 remote, R6 errors
    run(64'h1800_0000, "R5 remote");
    run(64'h1800_2000, "R5 remote");
    run(64'h1B00_0000, "R5 remote");
    run(64'h1C00_0000, "R6 double remote");
    run(64'h2000_0000, "R6 missing node");
    wr(3, 2, 0, 32'hD);
    wr(2, 2, 0, 32'h1234_5678);
    wr(3, 1, 0, 32'h5);
    run(64'h1800_0000, "R5 lowest node");
    wr(0, 2, 0, mk(1, 0, 0, 1, 1, 7)); wr(1, 2, 0, 32'hFFFF_FFFF);
    run(64'h1800_0100, "R5 remote mod");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule